// File: doc/BRIEF.md
# Random-Jitter Modulus Select Controller

This block decides, once per divider cycle, whether a two-modulus feedback divider counts by N or by N+1. Each time the divider signals the end of a cycle, the block steps a maximal-length Galois shift register to a fresh pseudorandom word. It then registers the result of comparing that word against a programmable fraction word. The divider reads the registered bit as its modulus control. Over a long run the share of N+1 cycles follows the fraction word, so the average division ratio sits between N and N+1 at a programmable point.

There is no accumulator, so no periodic carry pattern appears. The price is white frequency noise in the select sequence: no noise shaping is attempted. An enable input parks the divider on N and freezes the generator. The current pseudorandom word is brought out so that a test or monitor can watch the draws.

Top module: `rjit_modsel`

## Requirements
- R1: While `rst_n` is low at a clock edge, `mod_sel` goes to 0 and `rand_word` goes to the seed parameter, which is non-zero.
- R2: `rand_word` moves to a new value exactly at edges where `en` and `div_strobe` are both high, and holds at every other edge.
- R3: The generator never holds the all-zero word. With W-bit width it visits every non-zero W-bit value exactly once in 2^W-1 consecutive draws.
- R4: At the edge after a draw, `mod_sel` is 1 (meaning divide by N+1) exactly when the newly drawn `rand_word` is less than or equal to the `frac_word` sampled at the draw. Otherwise it is 0 (meaning divide by N).
- R5: With `en` high and `div_strobe` low, `mod_sel` keeps its value across the edge.
- R6: With `en` low at an edge, `mod_sel` becomes 0 and `div_strobe` has no effect: `rand_word` is unchanged.
- R7: Over any 2^W-1 consecutive draws with a fixed `frac_word` equal to F, the number of draws that select N+1 is exactly F. F=0 never selects N+1, and F=2^W-1 always selects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Enable. When low, select N and freeze the generator |
| div_strobe | input | 1 | One-cycle pulse per divider output event |
| frac_word | input | W | Fraction word F. The N+1 share is F/(2^W-1) |
| mod_sel | output | 1 | Registered modulus select: 1 = N+1, 0 = N |
| rand_word | output | W | Current pseudorandom word |

## Verification
The assertions assume that `frac_word` is steady whenever `en` and `div_strobe` are both high, and that `div_strobe` is a clean synchronous level, one clock wide per divider event. The bench changes the fraction word only between draws. It drives strobes every cycle, every third cycle, or in a random pattern, so both back-to-back and sparse events occur. Long disabled stretches with strobes still pulsing cover the freeze case. A second 16-bit instance runs one full generator period to check the exact select count at the default width.

// File: rtl/rjit_pkg.sv
// Shared constants for the random-jitter modulus select controller.
// Assumes the generator width is between 3 and 16 bits; other widths return 0.
package rjit_pkg;

    // Feedback mask of a maximal-length right-shifting Galois register per width.
    function automatic logic [15:0] galois_mask(input int unsigned width);
        case (width)
            3:       return 16'h0006;
            4:       return 16'h000C;
            5:       return 16'h0014;
            6:       return 16'h0030;
            7:       return 16'h0060;
            8:       return 16'h00B8;
            9:       return 16'h0110;
            10:      return 16'h0240;
            11:      return 16'h0500;
            12:      return 16'h0E08;
            13:      return 16'h1C80;
            14:      return 16'h3802;
            15:      return 16'h6000;
            16:      return 16'hB400;
            default: return 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/rjit_lfsr.sv
// Maximal-length Galois pseudorandom generator.
// Steps once per cycle when adv is high; otherwise holds.
// A zero state, which a correct run never reaches, is replaced by the seed.
// Assumes SEED is non-zero modulo 2^W and 3 <= W <= 16.
module rjit_lfsr #(
    parameter int unsigned W    = 16,
    parameter int unsigned SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [W-1:0] state,
    output logic [W-1:0] state_nxt
);
    localparam logic [15:0]  MASK16 = rjit_pkg::galois_mask(W);
    localparam logic [W-1:0] MASK   = MASK16[W-1:0];
    localparam logic [W-1:0] SEED_V = W'(SEED);

    // Next draw: one Galois step, or a jump back to the seed from zero.
    always_comb begin
        if (state == '0)
            state_nxt = SEED_V;
        else
            state_nxt = (state >> 1) ^ (state[0] ? MASK : '0);
    end

    // State register: loads the seed on reset and steps only on a draw.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= SEED_V;
        else if (adv)
            state <= state_nxt;
    end

    assert_word_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);

    assert_hold_no_draw_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(state));

    assert_moves_on_draw_R2: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> state != $past(state));

endmodule

// File: rtl/rjit_decide.sv
// Modulus decision register.
// On a draw, it registers whether the newly drawn word is at or below the
// fraction word. When disabled, it forces the N choice.
// Assumes frac is steady in the cycle of a draw.
module rjit_decide #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         draw,
    input  logic [W-1:0] word_new,
    input  logic [W-1:0] frac,
    output logic         sel
);
    logic pick_long;

    // Comparison: the long modulus wins when the word does not exceed the fraction.
    always_comb pick_long = (word_new <= frac);

    // Select register: reset and disable give N; a draw refreshes it; otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel <= 1'b0;
        else if (!en)
            sel <= 1'b0;
        else if (draw)
            sel <= pick_long;
    end

    assert_off_gives_n_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !sel);

    assert_hold_between_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !draw) |=> $stable(sel));

endmodule

// File: rtl/rjit_modsel.sv
// Random-jitter modulus select controller (top).
// For each divider event, it draws a fresh pseudorandom word and registers
// N+1 (mod_sel=1) when the word is at or below frac_word. Otherwise it
// registers N. The block adds no noise shaping.
// Assumes div_strobe is synchronous and one cycle per divider event.
module rjit_modsel #(
    parameter int unsigned W    = 16,
    parameter int unsigned SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         div_strobe,
    input  logic [W-1:0] frac_word,
    output logic         mod_sel,
    output logic [W-1:0] rand_word
);
    logic         draw;
    logic [W-1:0] word_nxt;

    // A draw happens only on an enabled divider event.
    always_comb draw = en & div_strobe;

    rjit_lfsr #(.W(W), .SEED(SEED)) u_lfsr (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (draw),
        .state     (rand_word),
        .state_nxt (word_nxt)
    );

    rjit_decide #(.W(W)) u_decide (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .draw     (draw),
        .word_new (word_nxt),
        .frac     (frac_word),
        .sel      (mod_sel)
    );

    assert_pick_matches_draw_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && div_strobe) |=> (mod_sel == (rand_word <= $past(frac_word))));

    assert_off_freezes_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(rand_word));

endmodule

// File: tb/rjit_modsel_tb.sv
// Bench: a behavioural model predicts both outputs every cycle from the
// inputs of the previous edge. Full-period counts check the select share.
module rjit_modsel_tb;
    localparam int W  = 8;
    localparam int WW = 16;
    localparam int PER  = (1 << W) - 1;
    localparam int PERW = (1 << WW) - 1;
    localparam int SEEDN = 8'h5A;
    localparam int SEEDW = 16'hACE1;
    localparam logic [WW-1:0] KW = 16'd40000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic stb = 1'b0;
    logic [W-1:0] kf = '0;
    logic mod_sel;
    logic [W-1:0] rw;
    logic stbw = 1'b0;
    logic selw;
    logic [WW-1:0] rww;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    rjit_modsel #(.W(W), .SEED(SEEDN)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .div_strobe(stb),
        .frac_word(kf), .mod_sel(mod_sel), .rand_word(rw)
    );

    rjit_modsel #(.W(WW), .SEED(SEEDW)) u_dut_wide (
        .clk(clk), .rst_n(rst_n), .en(1'b1), .div_strobe(stbw),
        .frac_word(KW), .mod_sel(selw), .rand_word(rww)
    );

    // Model state: inputs and outputs of the previous step.
    bit p_rst = 1, p_en = 0, p_stb = 0, p_stbw = 0;
    logic [W-1:0] p_k = '0, p_rw = '0;
    logic p_sel = 1'b0;
    int applied = 0, draws = 0, ones = 0;
    bit seen [PER+1];
    int applied_w = 0, ones_w = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_period();
        applied = 0; draws = 0; ones = 0;
        for (int i = 0; i <= PER; i++) seen[i] = 1'b0;
    endtask

    // One cycle: check outputs of the last edge, then apply new inputs.
    task automatic step(input bit rst_i, input bit en_i, input bit stb_i, input logic [W-1:0] k_i);
        @(negedge clk);
        if (p_rst) begin
            chk(mod_sel == 1'b0, "R1 sel", mod_sel, 0);
            chk(rw == W'(SEEDN), "R1 word", rw, SEEDN);
        end else if (!p_en) begin
            chk(mod_sel == 1'b0, "R6 sel", mod_sel, 0);
            chk(rw == p_rw, "R6 word", rw, p_rw);
        end else if (p_stb) begin
            chk(rw != p_rw, "R2 word moved", rw, p_rw);
            chk(rw != '0, "R3 nonzero", rw, 1);
            chk(mod_sel == (rw <= p_k), "R4 select", mod_sel, int'(rw <= p_k));
            draws++;
            if (mod_sel) ones++;
            chk(!seen[rw], "R3 repeat in period", rw, 0);
            seen[rw] = 1'b1;
        end else begin
            chk(mod_sel == p_sel, "R5 hold", mod_sel, p_sel);
            chk(rw == p_rw, "R2 hold", rw, p_rw);
        end
        if (!p_rst && p_stbw && selw) ones_w++;
        p_sel = mod_sel;
        p_rw  = rw;
        rst_n = !rst_i;
        en    = en_i;
        stb   = stb_i;
        kf    = k_i;
        stbw  = !rst_i && (applied_w < PERW);
        if (stbw) applied_w++;
        if (en_i && stb_i && !rst_i) applied++;
        p_rst = rst_i; p_en = en_i; p_stb = stb_i; p_k = k_i; p_stbw = stbw;
    endtask

    // Run one full period at fraction k with the given strobe spacing (0 = random).
    task automatic run_period(input logic [W-1:0] k, input int gap, input string req);
        clear_period();
        for (int c = 0; applied < PER; c++) begin
            bit s;
            s = (gap == 0) ? bit'($urandom_range(0, 1)) : ((c % gap) == 0);
            step(0, 1, s, k);
        end
        step(0, 1, 0, k);
        chk(draws == PER, {req, " draws"}, draws, PER);
        chk(ones == int'(k), {req, " count"}, ones, k);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) step(1, 0, 0, '0);
        // R1: reset state seen after the reset edges
        step(0, 0, 0, '0);
        // R7, R3: every-cycle strobes at F=64
        run_period(8'd64, 1, "R7 F=64");
        // R7: F=0 never selects N+1, sparse strobes
        run_period(8'd0, 3, "R7 F=0");
        // R7: F=max always selects N+1
        run_period(8'hFF, 1, "R7 F=max");
        // R6: disabled with strobes pulsing
        for (int i = 0; i < 20; i++) step(0, 0, 1'(i % 2), 8'hFF);
        // R7, R4: random strobe pattern at F=100
        run_period(8'd100, 0, "R7 F=100");
        // R5: hold with long gaps
        for (int i = 0; i < 10; i++) step(0, 1, 0, 8'd7);
        // wide instance: one full period at the default width
        while (applied_w < PERW) step(0, 1, 0, 8'd7);
        step(0, 1, 0, 8'd7);
        chk(ones_w == int'(KW), "R7 wide count", ones_w, KW);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1600000;
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule